// File: doc/BRIEF.md
# Three-Read Two-Write Register File with Operand Forwarding

This block is the integer register storage of a five-stage in-order pipeline. It serves one instruction per clock. The decode stage reads three operands at once: the first ALU operand, the second ALU operand and a shift count held in a register. The writeback stage can commit two results in the same cycle, for example the data returned by a load and the updated base address of that load. The decoder resolves processor-mode banking before the block sees an index. Every port therefore carries a flat physical index into a file of 27 words.

Results still in flight are not yet stored. Each read port has a forwarding mux that takes them from the execute stage, the buffer stage and the writeback ports of the current cycle. Each in-flight source has a valid bit and a destination index. The youngest matching source wins. The stored word is used only when no source matches. Reads are combinational within the cycle. Writes take effect at the rising clock edge.

Top module: `rf_top`

## Requirements
- R1: Each of the three read ports independently returns the stored word at its index in the same cycle when no forwarding source matches that index.
- R2: A load-port write (`ld_we` high, index below 27) stores `ld_wdata` at the rising edge, and later reads return it.
- R3: A base-port write (`bs_we` high, index below 27) stores `bs_wdata` at the rising edge, and later reads return it.
- R4: When both write ports are enabled with the same index, the stored result is the load-port data.
- R5: A valid execute-stage result whose index equals a read index is returned on that port, ahead of every other source.
- R6: With no execute match, a valid buffer-stage result with a matching index is returned, ahead of the writeback ports and storage.
- R7: With no execute or buffer match, an enabled write on the same cycle is forwarded to a matching read port: load-port data first, then base-port data.
- R8: A forwarding source affects a read only when its valid or enable bit is high and its index equals the read index.
- R9: Reset (`rst_n` low, sampled at the clock edge) clears all 27 words to zero.
- R10: Indices 27 to 31 address no storage: writes to them change no word, and a stored read of them returns zero. They can still match forwarding sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_idx | input | 15 | Three 5-bit read indices; port p occupies bits [5p+4:5p] (0 = operand A, 1 = operand B, 2 = shift count) |
| rd_data | output | 96 | Three 32-bit read results; port p occupies bits [32p+31:32p] |
| ex_vld | input | 1 | Execute-stage result valid |
| ex_idx | input | 5 | Execute-stage destination index |
| ex_data | input | 32 | Execute-stage result |
| bf_vld | input | 1 | Buffer-stage result valid |
| bf_idx | input | 5 | Buffer-stage destination index |
| bf_data | input | 32 | Buffer-stage result |
| ld_we | input | 1 | Load-data write enable |
| ld_widx | input | 5 | Load-data write index |
| ld_wdata | input | 32 | Load-data write value |
| bs_we | input | 1 | Base-writeback write enable |
| bs_widx | input | 5 | Base-writeback write index |
| bs_wdata | input | 32 | Base-writeback write value |

## Verification
Assertions run on every cycle and on every read port. They check that the execute and buffer sources take precedence when they match. They also check that each write port's data is read back one cycle later when nothing else forwards, including the case where the load port wins a collision with the base port. Other behaviour appears only in the bench's scenarios: the zero state after reset for all 27 words, the forwarding of same-cycle write data, and the fact that out-of-range writes leave storage untouched. The bench's behavioural model also covers the long-range effect of random mixes of sources with and without matching indices.

// File: rtl/rf_pkg.sv
package rf_pkg;
   // Forwarding source selected by a read port, youngest first
   typedef enum logic [2:0] {
      SRC_EX    = 3'd0,
      SRC_BF    = 3'd1,
      SRC_LD    = 3'd2,
      SRC_BS    = 3'd3,
      SRC_STORE = 3'd4
   } rf_src_e;
endpackage

// File: rtl/rf_store.sv
module rf_store #(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 27,
   parameter int IDX_W    = 5,
   parameter int NUM_RD   = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ld_we,
   input  logic [IDX_W-1:0]           ld_widx,
   input  logic [DATA_W-1:0]          ld_wdata,
   input  logic                       bs_we,
   input  logic [IDX_W-1:0]           bs_widx,
   input  logic [DATA_W-1:0]          bs_wdata,
   input  logic [NUM_RD*IDX_W-1:0]    rd_idx,
   output logic [NUM_RD*DATA_W-1:0]   rd_stored
);
   logic [DATA_W-1:0] mem [NUM_REGS];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
      logic ld_hit, bs_hit;
      assign ld_hit = ld_we && (ld_widx == IDX_W'(r));
      assign bs_hit = bs_we && (bs_widx == IDX_W'(r));
      always_ff @(posedge clk) begin
         if (!rst_n)      mem[r] <= '0;
         else if (ld_hit) mem[r] <= ld_wdata;
         else if (bs_hit) mem[r] <= bs_wdata;
      end
   end

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      logic [IDX_W-1:0] idx;
      assign idx = rd_idx[p*IDX_W +: IDX_W];
      always_comb begin
         rd_stored[p*DATA_W +: DATA_W] = '0;
         for (int r = 0; r < NUM_REGS; r++)
            if (idx == IDX_W'(r)) rd_stored[p*DATA_W +: DATA_W] = mem[r];
      end
   end
endmodule

// File: rtl/rf_fwd_mux.sv
module rf_fwd_mux
   import rf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 5
) (
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [DATA_W-1:0] stored,
   input  logic              ex_vld,
   input  logic [IDX_W-1:0]  ex_idx,
   input  logic [DATA_W-1:0] ex_data,
   input  logic              bf_vld,
   input  logic [IDX_W-1:0]  bf_idx,
   input  logic [DATA_W-1:0] bf_data,
   input  logic              ld_we,
   input  logic [IDX_W-1:0]  ld_widx,
   input  logic [DATA_W-1:0] ld_wdata,
   input  logic              bs_we,
   input  logic [IDX_W-1:0]  bs_widx,
   input  logic [DATA_W-1:0] bs_wdata,
   output logic [DATA_W-1:0] rd_data
);
   rf_src_e sel;

   always_comb begin
      if (ex_vld && ex_idx == rd_idx)       sel = SRC_EX;
      else if (bf_vld && bf_idx == rd_idx)  sel = SRC_BF;
      else if (ld_we && ld_widx == rd_idx)  sel = SRC_LD;
      else if (bs_we && bs_widx == rd_idx)  sel = SRC_BS;
      else                                  sel = SRC_STORE;
   end

   always_comb begin
      unique case (sel)
         SRC_EX:  rd_data = ex_data;
         SRC_BF:  rd_data = bf_data;
         SRC_LD:  rd_data = ld_wdata;
         SRC_BS:  rd_data = bs_wdata;
         default: rd_data = stored;
      endcase
   end
endmodule

// File: rtl/rf_top.sv
module rf_top #(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 27,
   parameter int IDX_W    = 5,
   parameter int NUM_RD   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_RD*IDX_W-1:0]  rd_idx,
   output logic [NUM_RD*DATA_W-1:0] rd_data,
   input  logic                     ex_vld,
   input  logic [IDX_W-1:0]         ex_idx,
   input  logic [DATA_W-1:0]        ex_data,
   input  logic                     bf_vld,
   input  logic [IDX_W-1:0]         bf_idx,
   input  logic [DATA_W-1:0]        bf_data,
   input  logic                     ld_we,
   input  logic [IDX_W-1:0]         ld_widx,
   input  logic [DATA_W-1:0]        ld_wdata,
   input  logic                     bs_we,
   input  logic [IDX_W-1:0]         bs_widx,
   input  logic [DATA_W-1:0]        bs_wdata
);
   localparam int MAX_IDX = 1 << IDX_W;

   if (NUM_REGS > MAX_IDX || NUM_REGS < 1) begin : g_bad_depth
      $error("rf_top: NUM_REGS must lie in 1..2**IDX_W");
   end
   if (NUM_RD < 1 || DATA_W < 1) begin : g_bad_width
      $error("rf_top: NUM_RD and DATA_W must be positive");
   end

   logic [NUM_RD*DATA_W-1:0] stored;

   rf_store #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .NUM_RD(NUM_RD)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .ld_we(ld_we), .ld_widx(ld_widx), .ld_wdata(ld_wdata),
      .bs_we(bs_we), .bs_widx(bs_widx), .bs_wdata(bs_wdata),
      .rd_idx(rd_idx), .rd_stored(stored)
   );

   for (genvar p = 0; p < NUM_RD; p++) begin : g_port
      rf_fwd_mux #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mux (
         .rd_idx  (rd_idx[p*IDX_W +: IDX_W]),
         .stored  (stored[p*DATA_W +: DATA_W]),
         .ex_vld  (ex_vld),  .ex_idx (ex_idx),  .ex_data (ex_data),
         .bf_vld  (bf_vld),  .bf_idx (bf_idx),  .bf_data (bf_data),
         .ld_we   (ld_we),   .ld_widx(ld_widx), .ld_wdata(ld_wdata),
         .bs_we   (bs_we),   .bs_widx(bs_widx), .bs_wdata(bs_wdata),
         .rd_data (rd_data[p*DATA_W +: DATA_W])
      );
   end
endmodule

// File: rtl/rf_chk.sv
module rf_chk #(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 27,
   parameter int IDX_W    = 5,
   parameter int NUM_RD   = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_RD*IDX_W-1:0]  rd_idx,
   input logic [NUM_RD*DATA_W-1:0] rd_data,
   input logic                     ex_vld,
   input logic [IDX_W-1:0]         ex_idx,
   input logic [DATA_W-1:0]        ex_data,
   input logic                     bf_vld,
   input logic [IDX_W-1:0]         bf_idx,
   input logic [DATA_W-1:0]        bf_data,
   input logic                     ld_we,
   input logic [IDX_W-1:0]         ld_widx,
   input logic [DATA_W-1:0]        ld_wdata,
   input logic                     bs_we,
   input logic [IDX_W-1:0]         bs_widx,
   input logic [DATA_W-1:0]        bs_wdata
);
   for (genvar p = 0; p < NUM_RD; p++) begin : g_p
      logic [IDX_W-1:0]  idx;
      logic [DATA_W-1:0] dat;
      logic              fwd_any;
      assign idx = rd_idx[p*IDX_W +: IDX_W];
      assign dat = rd_data[p*DATA_W +: DATA_W];
      assign fwd_any = (ex_vld && ex_idx == idx) || (bf_vld && bf_idx == idx) ||
                       (ld_we && ld_widx == idx) || (bs_we && bs_widx == idx);

      // R5
      ex_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ex_vld && ex_idx == idx) |-> dat == ex_data);

      // R6
      bf_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!(ex_vld && ex_idx == idx) && bf_vld && bf_idx == idx) |-> dat == bf_data);

      // R2 R4
      ld_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ld_we && ld_widx < IDX_W'(NUM_REGS)) |=>
            (!(idx == $past(ld_widx) && !fwd_any) || dat == $past(ld_wdata)));

      // R3
      bs_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bs_we && bs_widx < IDX_W'(NUM_REGS) && !(ld_we && ld_widx == bs_widx)) |=>
            (!(idx == $past(bs_widx) && !fwd_any) || dat == $past(bs_wdata)));
   end
endmodule

bind rf_top rf_chk #(
   .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .NUM_RD(NUM_RD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
   .ex_vld(ex_vld), .ex_idx(ex_idx), .ex_data(ex_data),
   .bf_vld(bf_vld), .bf_idx(bf_idx), .bf_data(bf_data),
   .ld_we(ld_we), .ld_widx(ld_widx), .ld_wdata(ld_wdata),
   .bs_we(bs_we), .bs_widx(bs_widx), .bs_wdata(bs_wdata)
);

// File: tb/rf_top_bench.sv
module rf_top_bench;
   localparam int PERIOD = 10;
   localparam int NR = 27;

   logic        clk = 0;
   logic        rst_n = 0;
   logic [14:0] rd_idx = '0;
   logic [95:0] rd_data;
   logic        ex_vld = 0, bf_vld = 0, ld_we = 0, bs_we = 0;
   logic [4:0]  ex_idx = 0, bf_idx = 0, ld_widx = 0, bs_widx = 0;
   logic [31:0] ex_data = 0, bf_data = 0, ld_wdata = 0, bs_wdata = 0;

   int checks = 0;
   int errors = 0;
   logic [31:0] model [NR];
   string       wtag  [NR];

   always #(PERIOD/2) clk = ~clk;

   rf_top u_rf_top (
      .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
      .ex_vld(ex_vld), .ex_idx(ex_idx), .ex_data(ex_data),
      .bf_vld(bf_vld), .bf_idx(bf_idx), .bf_data(bf_data),
      .ld_we(ld_we), .ld_widx(ld_widx), .ld_wdata(ld_wdata),
      .bs_we(bs_we), .bs_widx(bs_widx), .bs_wdata(bs_wdata)
   );

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      summary();
   end

   // Expected read value for one port, with the requirement it comes from
   task automatic expect_rd(input int idx, output logic [31:0] v, output string tag);
      if (ex_vld && ex_idx == idx)        begin v = ex_data;  tag = "R5"; end
      else if (bf_vld && bf_idx == idx)   begin v = bf_data;  tag = "R6"; end
      else if (ld_we && ld_widx == idx)   begin v = ld_wdata; tag = "R7"; end
      else if (bs_we && bs_widx == idx)   begin v = bs_wdata; tag = "R7"; end
      else if (idx < NR)                  begin v = model[idx]; tag = {"R1/R8/", wtag[idx]}; end
      else                                begin v = 0; tag = "R10"; end
   endtask

   task automatic check_ports();
      for (int p = 0; p < 3; p++) begin
         logic [31:0] e;
         string t;
         int i;
         i = int'(rd_idx[p*5 +: 5]);
         expect_rd(i, e, t);
         checks++;
         if (rd_data[p*32 +: 32] !== e) begin
            errors++;
            $display("FAIL %s port %0d idx %0d: got %h expected %h", t, p, i, rd_data[p*32 +: 32], e);
         end
      end
   endtask

   task automatic update_model();
      if (!rst_n) begin
         for (int r = 0; r < NR; r++) begin model[r] = 0; wtag[r] = "R9"; end
      end else begin
         if (ld_we && ld_widx < NR) begin
            model[ld_widx] = ld_wdata;
            wtag[ld_widx] = (bs_we && bs_widx == ld_widx) ? "R4" : "R2";
         end
         if (bs_we && bs_widx < NR && !(ld_we && ld_widx == bs_widx)) begin
            model[bs_widx] = bs_wdata; wtag[bs_widx] = "R3";
         end
      end
   endtask

   // One cycle: drive at falling edge, check, then advance model at rising edge
   task automatic step();
      #1 check_ports();
      @(posedge clk);
      update_model();
      @(negedge clk);
   endtask

   task automatic idle();
      ex_vld = 0; bf_vld = 0; ld_we = 0; bs_we = 0;
   endtask

   initial begin
      for (int r = 0; r < NR; r++) begin model[r] = 32'hx; wtag[r] = "R9"; end
      @(negedge clk);
      idle();
      @(posedge clk); update_model(); @(negedge clk);
      @(posedge clk); update_model(); @(negedge clk);
      rst_n = 1;
      // R9: every word reads zero after reset
      for (int r = 0; r < NR; r += 3) begin
         rd_idx = {5'(r+2 < NR ? r+2 : 0), 5'(r+1), 5'(r)};
         step();
      end
      // R4: collision on one index, load port must win
      ld_we = 1; ld_widx = 5; ld_wdata = 32'hAAAA_0005;
      bs_we = 1; bs_widx = 5; bs_wdata = 32'hBBBB_0005;
      rd_idx = {5'd0, 5'd1, 5'd5};
      step();
      idle(); rd_idx = {5'd5, 5'd5, 5'd5};
      step();
      // R10: write out of range, storage untouched, stored read is zero
      ld_we = 1; ld_widx = 28; ld_wdata = 32'hDEAD_BEEF;
      bs_we = 1; bs_widx = 31; bs_wdata = 32'hFEED_F00D;
      rd_idx = {5'd4, 5'd3, 5'd2};
      step();
      idle(); rd_idx = {5'd28, 5'd31, 5'd27};
      step();
      // Random mix of all sources with a narrow index range to force matches
      for (int c = 0; c < 3000; c++) begin
         ex_vld = 1'($urandom_range(0, 1)); ex_idx = 5'($urandom_range(0, 31)); ex_data = $urandom;
         bf_vld = 1'($urandom_range(0, 1)); bf_idx = 5'($urandom_range(0, 31)); bf_data = $urandom;
         ld_we  = 1'($urandom_range(0, 1)); ld_widx = 5'($urandom_range(0, 31)); ld_wdata = $urandom;
         bs_we  = 1'($urandom_range(0, 1)); bs_widx = 5'($urandom_range(0, 31)); bs_wdata = $urandom;
         if (c % 4 == 0) begin ex_idx = 5'($urandom_range(0, 7)); bf_idx = 5'($urandom_range(0, 7)); end
         for (int p = 0; p < 3; p++) rd_idx[p*5 +: 5] = 5'((c % 3 == 0) ? $urandom_range(0, 7) : $urandom_range(0, 31));
         step();
      end
      // R9: reset mid-run clears stored words again
      idle(); rst_n = 0;
      @(posedge clk); update_model(); @(negedge clk);
      rst_n = 1;
      for (int r = 0; r < NR; r += 3) begin
         rd_idx = {5'(r+2 < NR ? r+2 : 0), 5'(r+1), 5'(r)};
         step();
      end
      summary();
   end
endmodule